// File: doc/BRIEF.md
# Processor Heartbeat Watchdog Supervisor

This block supervises a processor through a heartbeat line. Software toggles the heartbeat pin from time to time. Each rising edge, falling edge or narrow glitch on that line restarts a timeout count. The count advances on a slow timebase tick. If the count reaches the limit picked by a 3-bit timeout code, the block raises a processor reset pulse of fixed width and drops its health flag. As long as the heartbeat stays stuck, the reset pulse comes back at a regular interval. The health flag stays low until the heartbeat moves again.

Three plain inputs switch the supervisor off: a floating heartbeat line, a failed supply and backup mode. Any one of them forces the outputs to their quiet state. The heartbeat reaches the clock domain through toggle flops and a synchronizer, so a glitch shorter than one clock is still seen. All outputs come from registers.

Top module: `wdog_supervisor`

## Requirements
- R1: During reset and on the first clock after it, `wdog_ok_o` is 1 and `cpu_rst_o` is 0.
- R2: A rising or a falling edge on `hb_i` restarts the timeout count and sets `wdog_ok_o` to 1. The clock edge that acts on it is the third rising clock edge after the change. Edges that come closer together than the selected period never cause a reset.
- R3: A high pulse on `hb_i` that is shorter than one clock period counts as a heartbeat event, with the same timing as in R2.
- R4: If a heartbeat event never arrives, the timeout fires on the tick that brings the count to `TMO_TICKS[tmo_sel_i]`. On the clock after that tick, `cpu_rst_o` goes to 1 and `wdog_ok_o` goes to 0, both together.
- R5: A reset pulse lasts exactly `RST_TICKS` ticks. It changes only on a tick and ignores heartbeat events.
- R6: Once `wdog_ok_o` is 0, it stays 0 across any number of reset pulses. It returns to 1 only after a heartbeat event (R2/R3) or while the block is disabled.
- R7: While the heartbeat stays stuck, the count restarts when each reset pulse ends, so the pulses repeat. The interval from the start of one pulse to the start of the next is the selected timeout plus `RST_TICKS` ticks.
- R8: While `hb_float_i`, `supply_fail_i` or `backup_i` is 1, the next clock sets `wdog_ok_o` to 1 and `cpu_rst_o` to 0, even in the middle of a pulse. The count is discarded. Timing starts afresh one clock after the inputs are released.
- R9: `tmo_sel_i` picks an entry of the `TMO_TICKS` table (3-bit index; code 000 is the default and means 150 ticks, which is 1.5 s at a 10 ms tick). The code is read only when the count restarts, so a change in the middle of a count applies from the next restart.
- R10: The first timeout after reset is released uses the code present one clock after the release. It lasts the full programmed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable, one clock wide per tick |
| hb_i | input | 1 | Processor heartbeat, asynchronous |
| hb_float_i | input | 1 | Heartbeat line sensed as floating; disables |
| supply_fail_i | input | 1 | Supply below threshold; disables |
| backup_i | input | 1 | Backup mode active; disables |
| tmo_sel_i | input | 3 | Timeout code, index into `TMO_TICKS` |
| wdog_ok_o | output | 1 | Health flag, 0 after a timeout |
| cpu_rst_o | output | 1 | Processor reset pulse, active high |

## Verification
The bench targets sub-clock glitches on the heartbeat. A design that relies on the level synchronizer alone would let those pulses go by and fire false resets. It holds the heartbeat stuck over several periods. A design that restarts the count on the wrong event would space the repeated pulses wrongly, or would stop after the first pulse. It changes the timeout code in the middle of a count, and it asserts each disable input while a pulse is active. These steps expose code sampling done at the wrong time, and a pulse that runs on through a disable. A heartbeat edge that arrives during a pulse must bring the flag back without cutting the pulse short.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_ARM   = 2'd0,
    WD_WATCH = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_edge_capture.sv
module wdog_edge_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  output logic evt_o
);
  localparam int NCH = 2;

  logic tog_rise_q, tog_fall_q;
  logic [NCH-1:0] tog_v, sync_v, prev_q, chg_v;

  // The toggle flops run on the heartbeat itself, so any pulse width is kept
  always_ff @(posedge hb_i or negedge rst_ni) begin
    if (!rst_ni) tog_rise_q <= 1'b0;
    else         tog_rise_q <= ~tog_rise_q;
  end

  always_ff @(negedge hb_i or negedge rst_ni) begin
    if (!rst_ni) tog_fall_q <= 1'b0;
    else         tog_fall_q <= ~tog_fall_q;
  end

  always_comb tog_v = {tog_fall_q, tog_rise_q};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (tog_v[g]),
      .q_o   (sync_v[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sync_v[g];
    end

    assign chg_v[g] = sync_v[g] ^ prev_q[g];
  end

  assign evt_o = |chg_v;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int          SEL_W = 3,
  parameter int unsigned TMO_TICKS [2**SEL_W] = '{150, 10, 25, 50, 100, 200, 300, 600},
  parameter int unsigned RST_TICKS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             evt_i,
  input  logic             inhibit_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ok_o,
  output logic             rst_o
);
  function automatic int unsigned peak_ticks();
    int unsigned m;
    m = RST_TICKS;
    for (int i = 0; i < 2**SEL_W; i++) begin
      if (TMO_TICKS[i] > m) m = TMO_TICKS[i];
    end
    return m;
  endfunction

  localparam int unsigned PEAK  = peak_ticks();
  localparam int          CNT_W = $clog2(PEAK + 1);
  localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_TICKS);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, lim_q, cnt_nxt, sel_lim;
  logic             ok_q, rst_q;

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    sel_lim = CNT_W'(TMO_TICKS[sel_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_ARM;
      cnt_q   <= '0;
      lim_q   <= '0;
      ok_q    <= 1'b1;
      rst_q   <= 1'b0;
    end else if (inhibit_i) begin
      state_q <= WD_ARM;
      cnt_q   <= '0;
      ok_q    <= 1'b1;
      rst_q   <= 1'b0;
    end else begin
      unique case (state_q)
        WD_ARM: begin
          lim_q   <= sel_lim;
          cnt_q   <= '0;
          state_q <= WD_WATCH;
        end
        WD_WATCH: begin
          if (evt_i) begin
            cnt_q <= '0;
            lim_q <= sel_lim;
            ok_q  <= 1'b1;
          end else if (tick_i) begin
            if (cnt_nxt == lim_q) begin
              state_q <= WD_PULSE;
              cnt_q   <= '0;
              ok_q    <= 1'b0;
              rst_q   <= 1'b1;
            end else begin
              cnt_q <= cnt_nxt;
            end
          end
        end
        WD_PULSE: begin
          if (evt_i) ok_q <= 1'b1;
          if (tick_i) begin
            if (cnt_nxt == RST_LIM) begin
              state_q <= WD_WATCH;
              cnt_q   <= '0;
              lim_q   <= sel_lim;
              rst_q   <= 1'b0;
            end else begin
              cnt_q <= cnt_nxt;
            end
          end
        end
        default: state_q <= WD_ARM;
      endcase
    end
  end

  assign ok_o  = ok_q;
  assign rst_o = rst_q;
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int          SEL_W       = 3,
  parameter int unsigned TMO_TICKS [2**SEL_W] = '{150, 10, 25, 50, 100, 200, 300, 600},
  parameter int unsigned RST_TICKS   = 20,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hb_i,
  input  logic             hb_float_i,
  input  logic             supply_fail_i,
  input  logic             backup_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  output logic             wdog_ok_o,
  output logic             cpu_rst_o
);
  logic hb_evt;
  logic inhibit;

  assign inhibit = hb_float_i | supply_fail_i | backup_i;

  wdog_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hb_i  (hb_i),
    .evt_o (hb_evt)
  );

  wdog_timer #(
    .SEL_W    (SEL_W),
    .TMO_TICKS(TMO_TICKS),
    .RST_TICKS(RST_TICKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .evt_i    (hb_evt),
    .inhibit_i(inhibit),
    .sel_i    (tmo_sel_i),
    .ok_o     (wdog_ok_o),
    .rst_o    (cpu_rst_o)
  );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic inhibit,
  input logic evt,
  input logic ok,
  input logic cpu_rst
);
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (ok && !cpu_rst)); // R8

  AST_TRIP_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> !ok); // R4

  AST_TRIP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $past(tick)); // R4

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst && !tick && !inhibit) |=> cpu_rst); // R5

  AST_PULSE_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> ($past(tick) || $past(inhibit))); // R5

  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> ($past(evt) || $past(inhibit))); // R6
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .tick   (tick_i),
  .inhibit(inhibit),
  .evt    (hb_evt),
  .ok     (wdog_ok_o),
  .cpu_rst(cpu_rst_o)
);

// File: tb/tb_wdog_supervisor.sv
`timescale 1ns/100ps
module tb_wdog_supervisor;
  localparam int unsigned TB_TMO [8] = '{12, 4, 6, 8, 10, 14, 16, 20};
  localparam int unsigned TB_RST = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, hb = 1'b0;
  logic hb_float = 1'b0, sfail = 1'b0, backup = 1'b0;
  logic [2:0] sel = 3'd0;
  logic wdog_ok, cpu_rst;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  int edge_cnt = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  wdog_supervisor #(.SEL_W(3), .TMO_TICKS(TB_TMO), .RST_TICKS(TB_RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hb_i(hb),
    .hb_float_i(hb_float), .supply_fail_i(sfail), .backup_i(backup),
    .tmo_sel_i(sel), .wdog_ok_o(wdog_ok), .cpu_rst_o(cpu_rst));

  // timebase: one tick every third clock
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 0);
  end

  // behavioural reference
  int  m_state = 0, m_cnt = 0, m_lim = 0, e1 = 0, e2 = 0, e3 = 0;
  bit  m_ok = 1'b1, m_rst = 1'b0, m_evt;
  int  m_rises = 0, d_rises = 0;
  bit  d_rst_prev = 1'b0, m_rst_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_ok = 1'b1; m_rst = 1'b0;
      e1 = 0; e2 = 0; e3 = 0;
    end else begin
      m_evt = (e2 != e3);
      e3 = e2; e2 = e1; e1 = edge_cnt;
      if (hb_float || sfail || backup) begin
        m_state = 0; m_cnt = 0; m_ok = 1'b1; m_rst = 1'b0;
      end else if (m_state == 0) begin
        m_lim = TB_TMO[sel]; m_cnt = 0; m_state = 1;
      end else if (m_state == 1) begin
        if (m_evt) begin
          m_cnt = 0; m_lim = TB_TMO[sel]; m_ok = 1'b1;
        end else if (tick) begin
          if (m_cnt + 1 == m_lim) begin
            m_state = 2; m_cnt = 0; m_ok = 1'b0; m_rst = 1'b1;
          end else m_cnt = m_cnt + 1;
        end
      end else begin
        if (m_evt) m_ok = 1'b1;
        if (tick) begin
          if (m_cnt + 1 == TB_RST) begin
            m_state = 1; m_cnt = 0; m_lim = TB_TMO[sel]; m_rst = 1'b0;
          end else m_cnt = m_cnt + 1;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      compared++;
      if (wdog_ok !== m_ok || cpu_rst !== m_rst) begin
        mismatched++;
        $display("FAIL %s cycle %0d: wdog_ok=%b cpu_rst=%b expected wdog_ok=%b cpu_rst=%b",
                 cur_req, cycles, wdog_ok, cpu_rst, m_ok, m_rst);
      end
      if (cpu_rst && !d_rst_prev) d_rises++;
      if (m_rst && !m_rst_prev) m_rises++;
    end
    d_rst_prev = cpu_rst;
    m_rst_prev = m_rst;
  end

  task automatic chk(string req, int got, int exp, string what);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_hb();
    @(negedge clk);
    hb = ~hb;
    edge_cnt++;
  endtask

  task automatic glitch_hb();
    @(negedge clk);
    #0.5 hb = 1'b1;
    #0.5 hb = 1'b0;
    edge_cnt += 2;
  endtask

  task automatic wait_rst(bit lvl);
    for (int i = 0; i < 400; i++) begin
      if (cpu_rst == lvl) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    edge_cnt = 0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  int base_d, base_m;

  initial begin
    cyc(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", wdog_ok, 1, "wdog_ok after reset");
    chk("R1", cpu_rst, 0, "cpu_rst after reset");

    cur_req = "R2";
    base_d = d_rises;
    for (int i = 0; i < 6; i++) begin cyc(24); toggle_hb(); end
    chk("R2", d_rises - base_d, 0, "resets while heartbeat active");

    cur_req = "R4";
    base_d = d_rises; base_m = m_rises;
    cyc(45);
    chk("R4", d_rises - base_d, m_rises - base_m, "first timeout pulses");
    chk("R4", wdog_ok, 0, "flag after timeout");

    cur_req = "R7";
    base_d = d_rises; base_m = m_rises;
    cyc(130);
    chk("R7", d_rises - base_d, m_rises - base_m, "repeated pulses while stuck");
    chk("R7", (d_rises - base_d) >= 2 ? 1 : 0, 1, "at least two repeats");

    cur_req = "R5";
    wait_rst(1'b1);
    toggle_hb();
    cyc(4);
    chk("R5", cpu_rst, m_rst, "pulse kept through heartbeat edge");

    cur_req = "R6";
    cyc(3);
    chk("R6", wdog_ok, 1, "flag restored by heartbeat edge");

    cur_req = "R3";
    base_d = d_rises;
    for (int i = 0; i < 8; i++) begin cyc(20); glitch_hb(); end
    chk("R3", d_rises - base_d, 0, "resets while glitch heartbeat active");

    cur_req = "R9";
    sel = 3'd1;
    toggle_hb();
    base_d = d_rises; base_m = m_rises;
    cyc(20);
    chk("R9", d_rises - base_d, m_rises - base_m, "short code timeout");
    toggle_hb();
    cyc(3);
    sel = 3'd5;
    cyc(20);
    sel = 3'd0;
    cyc(60);
    chk("R9", d_rises - base_d, m_rises - base_m, "code change mid count");

    cur_req = "R8";
    wait_rst(1'b1);
    hb_float = 1'b1; cyc(2);
    chk("R8", cpu_rst, 0, "floating disables pulse");
    chk("R8", wdog_ok, 1, "floating holds flag high");
    hb_float = 1'b0; wait_rst(1'b1);
    sfail = 1'b1; cyc(2);
    chk("R8", cpu_rst, 0, "supply fail disables pulse");
    sfail = 1'b0; wait_rst(1'b1);
    backup = 1'b1; cyc(50);
    chk("R8", cpu_rst, 0, "backup mode disables pulse");
    chk("R8", wdog_ok, 1, "backup mode holds flag high");
    backup = 1'b0;
    cyc(10);

    cur_req = "R10";
    sel = 3'd2;
    do_reset();
    base_d = d_rises; base_m = m_rises;
    cyc(30);
    chk("R10", d_rises - base_d, m_rises - base_m, "first period after reset");
    chk("R10", cpu_rst, m_rst, "pulse state after first period");
    cyc(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    mismatched++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule